// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a simple host request port and one 1M x 16 extended-data-out DRAM. Each host request carries a word address, a write flag, write data and two byte enables. The controller splits the address into a row half and a column half and puts them on one shared address bus. It then produces the row strobe, the two per-byte column strobes, the write strobe and the output-enable strobe. Every interval the DRAM needs is a parameter counted in controller clocks: the row-to-column delay, column low time, column precharge, row precharge, minimum row-low time and maximum row-low time. The defaults assume a 100 MHz clock and the fastest speed grade.

A row stays open after an access. While requests keep hitting that row, each one costs only a column cycle. A request to another row, a refresh grant, or a row-low time near its limit closes the row and waits out the full row precharge. Writes always use early-write sequencing: the write strobe falls at least one clock before any column strobe, so the DRAM never drives its data pins during a write. A read captures the DRAM data on the clock edge that ends the column-low phase and reports it with a one-cycle valid pulse.

The state machine has six states. PRECHARGE (the reset state) moves to IDLE when its timer runs out. IDLE accepts a request and moves to ROW_ACT, or moves to REFRESH_HOLD when a refresh grant is present. ROW_ACT moves to CAS_LOW after the row-to-column delay. CAS_LOW moves to CAS_PRE after the column-low count. CAS_PRE has three exits once its precharge count ends: a page hit goes back to CAS_LOW, a close goes to PRECHARGE, and with nothing to do it stays put. REFRESH_HOLD moves to PRECHARGE when the grant is withdrawn.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the following are high: the row strobe, both column strobes, the write strobe and the output enable. In that same state `rd_valid`, `dram_dq_oe` and `req_ready` are low.
- R2: The word address is split as row = `req_addr[19:10]` and column = `req_addr[9:0]`. The row is on `dram_addr` when the row strobe falls. The column is on `dram_addr` when a column strobe falls.
- R3: A word written with both byte enables set reads back unchanged at the same address.
- R4: Byte enable bit 0 drives `dram_casl_n`, which covers data bits 7:0. Bit 1 drives `dram_cash_n`, which covers bits 15:8. A write with one enable leaves the other byte of the stored word unchanged.
- R5: For a write, the write strobe is low on at least the clock before the column strobe falls. The output enable is high whenever the write strobe is low. `dram_dq_oe` is high only while a column strobe is low for a write.
- R6: A request to the open row produces no new row-strobe fall and is accepted from CAS_PRE.
- R7: The row strobe stays high for at least T_RP+1 cycles before it falls again. A request to a different row first closes the open row.
- R8: The row strobe stays low for at least T_RAS_MIN cycles. The first column strobe falls T_RCD or more cycles after the row strobe. Each column-low phase lasts exactly T_CAS cycles, and consecutive column-low phases are separated by at least T_CP high cycles.
- R9: The row strobe is never low for more than T_RASP_MAX consecutive cycles. This holds during an unbroken stream of page hits and on an idle open page.
- R10: The read data is captured T_CAS cycles after the column strobe falls. `rd_valid` is high for exactly one cycle per read.
- R11: While `ref_grant` is high, `req_ready` stays low. An open row is closed, and every strobe then stays high until the grant is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in the upper half, column in the lower half |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| rd_data | output | 16 | Captured read data |
| ref_grant | input | 1 | Refresh owns the DRAM; park the bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-byte column strobe, active low |
| dram_cash_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the data pin drivers |
| dram_dq_in | input | 16 | Data read from the DRAM pins |

## Verification
The assertions assume a host that holds its request fields stable from `req_valid` until acceptance. They also assume a refresh agent that only raises `ref_grant` and never drives the strobes through this block. Under those conditions, strobe ordering, run lengths and ready gating follow from the controller alone. The stimulus changes request fields only after an acceptance. It keeps addresses inside a small set of rows and columns, whose extra high bits are still distinct, so that a small memory model in the bench can mirror each stored word. The maximum row-low time is reduced for the bench so that forced closes occur within short hit streams.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_ACT,
        ST_CAS_LOW,
        ST_CAS_PRE,
        ST_PRECHARGE,
        ST_REFRESH_HOLD
    } edo_state_t;

    localparam int LANES = 2;

endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/edo_ras_age.sv
module edo_ras_age #(
    parameter int T_RAS_MIN = 5,
    parameter int HIT_LIMIT = 100,
    parameter int AW        = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_active,
    output logic min_met,
    output logic hit_ok
);

    logic [AW-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (!ras_active) begin
            age <= '0;
        end else if (age <= AW'(HIT_LIMIT)) begin
            age <= age + 1'b1;
        end
    end

    assign min_met = (age >= AW'(T_RAS_MIN - 1));
    assign hit_ok  = (age <= AW'(HIT_LIMIT));

endmodule

// File: rtl/edo_req_hold.sv
module edo_req_hold #(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              in_we,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [BE_W-1:0]   in_be,
    output logic              h_we,
    output logic [ROW_W-1:0]  h_row,
    output logic [COL_W-1:0]  h_col,
    output logic [DATA_W-1:0] h_wdata,
    output logic [BE_W-1:0]   h_be,
    output logic              row_match
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_we    <= 1'b0;
            h_row   <= '0;
            h_col   <= '0;
            h_wdata <= '0;
            h_be    <= '0;
        end else if (capture) begin
            h_we    <= in_we;
            h_row   <= in_row;
            h_col   <= in_col;
            h_wdata <= in_wdata;
            h_be    <= in_be;
        end
    end

    assign row_match = (in_row == h_row);

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_ctrl_pkg::*;
#(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 10,
    parameter int DATA_W     = 16,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int T_CP       = 1,
    parameter int T_RP       = 3,
    parameter int T_RAS_MIN  = 5,
    parameter int T_RASP_MAX = 12500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_we,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [LANES-1:0]         req_be,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     ref_grant,
    output logic                     dram_ras_n,
    output logic                     dram_casl_n,
    output logic                     dram_cash_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DATA_W-1:0]        dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [DATA_W-1:0]        dram_dq_in
);

    localparam int ADDR_W    = ROW_W + COL_W;
    localparam int MUX_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int TW        = $clog2(T_RCD + T_CAS + T_CP + T_RP + 2) + 1;
    localparam int HIT_LIMIT = T_RASP_MAX - 1 - T_CAS - T_CP;
    localparam int AW        = $clog2(T_RASP_MAX + 1) + 1;

    edo_state_t state, nxt;

    logic          t_load, t_done;
    logic [TW-1:0] t_val;
    logic          accept, hit_acc, close_row;
    logic          min_met, hit_ok, ras_active;

    logic              h_we, row_match;
    logic [ROW_W-1:0]  h_row;
    logic [COL_W-1:0]  h_col;
    logic [DATA_W-1:0] h_wdata;
    logic [LANES-1:0]  h_be;
    logic [LANES-1:0]  lane_cas_n;

    edo_phase_timer #(.W(TW), .RST_VAL(T_RP)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    edo_ras_age #(.T_RAS_MIN(T_RAS_MIN), .HIT_LIMIT(HIT_LIMIT), .AW(AW)) age_i (
        .clk(clk), .rst_n(rst_n), .ras_active(ras_active),
        .min_met(min_met), .hit_ok(hit_ok)
    );

    edo_req_hold #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BE_W(LANES)) hold_i (
        .clk(clk), .rst_n(rst_n), .capture(accept),
        .in_we(req_we), .in_row(req_addr[ADDR_W-1:COL_W]), .in_col(req_addr[COL_W-1:0]),
        .in_wdata(req_wdata), .in_be(req_be),
        .h_we(h_we), .h_row(h_row), .h_col(h_col), .h_wdata(h_wdata), .h_be(h_be),
        .row_match(row_match)
    );

    assign ras_active = (state == ST_ROW_ACT) || (state == ST_CAS_LOW) || (state == ST_CAS_PRE);
    assign close_row  = min_met && (ref_grant || !hit_ok || (req_valid && !row_match));

    // next state, phase timer load and request acceptance
    always_comb begin
        nxt     = state;
        t_load  = 1'b0;
        t_val   = '0;
        accept  = 1'b0;
        hit_acc = 1'b0;
        unique case (state)
            ST_PRECHARGE: begin
                if (t_done) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_grant) begin
                    nxt = ST_REFRESH_HOLD;
                end else if (req_valid) begin
                    accept = 1'b1;
                    nxt    = ST_ROW_ACT;
                    t_load = 1'b1;
                    t_val  = TW'(T_RCD - 1);
                end
            end
            ST_ROW_ACT: begin
                if (t_done) begin
                    nxt    = ST_CAS_LOW;
                    t_load = 1'b1;
                    t_val  = TW'(T_CAS - 1);
                end
            end
            ST_CAS_LOW: begin
                if (t_done) begin
                    nxt    = ST_CAS_PRE;
                    t_load = 1'b1;
                    t_val  = TW'(T_CP - 1);
                end
            end
            ST_CAS_PRE: begin
                if (t_done) begin
                    if (close_row) begin
                        nxt    = ST_PRECHARGE;
                        t_load = 1'b1;
                        t_val  = TW'(T_RP - 1);
                    end else if (req_valid && row_match && hit_ok && !ref_grant) begin
                        accept  = 1'b1;
                        hit_acc = 1'b1;
                        nxt     = ST_CAS_LOW;
                        t_load  = 1'b1;
                        t_val   = TW'(T_CAS - 1);
                    end
                end
            end
            ST_REFRESH_HOLD: begin
                if (!ref_grant) begin
                    nxt    = ST_PRECHARGE;
                    t_load = 1'b1;
                    t_val  = TW'(T_RP - 1);
                end
            end
            default: nxt = ST_PRECHARGE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRECHARGE;
        else        state <= nxt;
    end

    // per-byte column strobes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_cas_n[g] = !((state == ST_CAS_LOW) && h_be[g]);
    end
    assign dram_casl_n = lane_cas_n[0];
    assign dram_cash_n = lane_cas_n[1];

    // strobe, address and data outputs
    always_comb begin
        dram_ras_n  = !ras_active;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_addr   = MUX_W'(h_row);
        dram_dq_out = h_wdata;
        dram_dq_oe  = 1'b0;
        req_ready   = accept;
        unique case (state)
            ST_ROW_ACT: begin
                dram_we_n = !h_we;
            end
            ST_CAS_LOW: begin
                dram_addr  = MUX_W'(h_col);
                dram_we_n  = !h_we;
                dram_oe_n  = h_we;
                dram_dq_oe = h_we;
            end
            ST_CAS_PRE: begin
                dram_we_n = !(hit_acc && req_we);
                dram_oe_n = h_we || (hit_acc && req_we);
            end
            default: ;
        endcase
    end

    // read capture at the end of the column-low phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_CAS_LOW) && t_done && !h_we;
            if ((state == ST_CAS_LOW) && t_done && !h_we) rd_data <= dram_dq_in;
        end
    end

endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
    parameter int T_RP       = 3,
    parameter int T_RAS_MIN  = 5,
    parameter int T_RASP_MAX = 12500
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic ref_grant,
    input logic rd_valid,
    input logic dram_ras_n,
    input logic dram_casl_n,
    input logic dram_cash_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);

    localparam int CW = $clog2(T_RASP_MAX + T_RP + 2) + 1;

    logic [CW-1:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else if (dram_ras_n) begin
            lo_cnt <= '0;
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    a_r5_we_leads_cas: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_casl_n) || $fell(dram_cash_n)) && !dram_we_n) |-> !$past(dram_we_n));

    a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);

    a_r5_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && (!dram_casl_n || !dram_cash_n)));

    a_r8_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_casl_n || !dram_cash_n) |-> (!dram_ras_n && $past(!dram_ras_n)));

    a_r7_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && hi_cnt != '0) |-> (hi_cnt >= CW'(T_RP + 1)));

    a_r8_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n && lo_cnt != '0) |-> (lo_cnt >= CW'(T_RAS_MIN)));

    a_r9_ras_low_max: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (lo_cnt < CW'(T_RASP_MAX)));

    a_r10_rd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r11_grant_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> !req_ready);

endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
    .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RASP_MAX(T_RASP_MAX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ref_grant(ref_grant),
    .rd_valid(rd_valid), .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n),
    .dram_cash_n(dram_cash_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_page_ctrl_tb_top.sv
module edo_page_ctrl_tb_top;

    localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, T_RAS_MIN = 5, T_RASP_MAX = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0, ref_grant = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data, dq_out, dq_in;
    logic        ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
    logic [9:0]  dram_addr;

    always #5 clk = ~clk;

    edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                    .T_RAS_MIN(T_RAS_MIN), .T_RASP_MAX(T_RASP_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_grant(ref_grant),
        .dram_ras_n(ras_n), .dram_casl_n(casl_n), .dram_cash_n(cash_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    int errors = 0, checks = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // DRAM model and protocol monitor, sampled at the falling clock edge
    logic [15:0] mem [0:31];
    logic [15:0] shadow [0:31];
    logic [9:0]  row_lat = '0, col_lat = '0;
    assign dq_in = mem[{row_lat[1:0], col_lat[2:0]}];

    int cyc = 0, hi_run = 0, lo_run = 0, max_lo = 0, ras_falls = 0;
    int ras_fall_cyc = 0, cas_fall_cyc = 0, cas_rise_cyc = 0;
    int rp_viol = 0, rasmin_viol = 0, rcd_viol = 0, cp_viol = 0, caslen_viol = 0;
    int we_viol = 0, drv_viol = 0, lat_viol = 0;
    bit first_cas = 1'b0;
    logic p_ras = 1'b1, p_casl = 1'b1, p_cash = 1'b1, p_we = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!ras_n && p_ras) begin
                ras_falls++;
                row_lat = dram_addr;
                if (hi_run < T_RP + 1) rp_viol++;
                first_cas = 1'b1;
                ras_fall_cyc = cyc;
            end
            if (ras_n && !p_ras && lo_run < T_RAS_MIN) rasmin_viol++;
            if (ras_n) begin hi_run++; lo_run = 0; end
            else begin lo_run++; hi_run = 0; if (lo_run > max_lo) max_lo = lo_run; end
            if ((!casl_n || !cash_n) && p_casl && p_cash) begin
                col_lat = dram_addr;
                if (first_cas && (cyc - ras_fall_cyc) < T_RCD) rcd_viol++;
                if (!first_cas && (cyc - cas_rise_cyc) < T_CP) cp_viol++;
                first_cas = 1'b0;
                cas_fall_cyc = cyc;
            end
            if (casl_n && cash_n && (!p_casl || !p_cash)) begin
                if (cyc - cas_fall_cyc != T_CAS) caslen_viol++;
                cas_rise_cyc = cyc;
            end
            if ((!casl_n && p_casl) || (!cash_n && p_cash)) begin
                if (!we_n && (p_we || !oe_n)) we_viol++;
                if (!we_n && !dq_oe) drv_viol++;
                if (we_n && dq_oe) drv_viol++;
            end
            if (!casl_n && p_casl && !we_n) mem[{row_lat[1:0], col_lat[2:0]}][7:0] = dq_out[7:0];
            if (!cash_n && p_cash && !we_n) mem[{row_lat[1:0], col_lat[2:0]}][15:8] = dq_out[15:8];
            if (rd_valid && (cyc - cas_fall_cyc != T_CAS)) lat_viol++;
        end
        p_ras = ras_n; p_casl = casl_n; p_cash = cash_n; p_we = we_n;
    end

    function automatic logic [9:0] rowf(input int r); return 10'(r | (r << 8)); endfunction
    function automatic logic [9:0] colf(input int c); return 10'(c | (c << 7)); endfunction
    function automatic logic [15:0] pat(input int i); return 16'((i * 16'h01F3) ^ 16'hC35A); endfunction

    task automatic host_issue(input bit we, input int r, input int c, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk); #2;
        req_valid = 1'b1; req_we = we; req_addr = {rowf(r), colf(c)}; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin @(negedge clk); #3; end
        @(negedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic host_read(input int r, input int c, output logic [15:0] d);
        host_issue(1'b0, r, c, 16'h0, 2'b11);
        while (!rd_valid) @(negedge clk);
        d = rd_data;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        int f0, f1, bad;
        for (int i = 0; i < 32; i++) begin mem[i] = 16'h0; shadow[i] = 16'h0; end
        repeat (4) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({ras_n, casl_n, cash_n, we_n, oe_n} == 5'b11111, "R1 strobes idle",
              {ras_n, casl_n, cash_n, we_n, oe_n}, 5'b11111);
        check({rd_valid, dq_oe, req_ready} == 3'b000, "R1 flags low",
              {rd_valid, dq_oe, req_ready}, 3'b000);

        // R3 word write sweep over 4 rows x 8 columns
        for (int i = 0; i < 32; i++) begin
            host_issue(1'b1, i / 8, i % 8, pat(i), 2'b11);
            shadow[i] = pat(i);
        end
        for (int i = 0; i < 32; i++) begin
            host_read(i / 8, i % 8, d);
            check(d == shadow[i], "R3 word readback", d, shadow[i]);
            check(row_lat == rowf(i / 8), "R2 row half", row_lat, rowf(i / 8));
            check(col_lat == colf(i % 8), "R2 column half", col_lat, colf(i % 8));
        end

        // R4 byte writes: even words lower lane, odd words upper lane
        for (int i = 0; i < 32; i++) begin
            logic [15:0] nd;
            nd = ~pat(i + 7);
            if (i % 2 == 0) begin
                host_issue(1'b1, i / 8, i % 8, nd, 2'b01);
                shadow[i][7:0] = nd[7:0];
            end else begin
                host_issue(1'b1, i / 8, i % 8, nd, 2'b10);
                shadow[i][15:8] = nd[15:8];
            end
        end
        for (int i = 0; i < 32; i++) begin
            host_read(i / 8, i % 8, d);
            check(d == shadow[i], "R4 byte lane merge", d, shadow[i]);
        end

        // R6 page hits, R7 row miss
        host_read(2, 0, d);
        f0 = ras_falls;
        for (int c = 1; c < 5; c++) begin
            host_read(2, c, d);
            check(d == shadow[16 + c], "R6 hit data", d, shadow[16 + c]);
        end
        check(ras_falls == f0, "R6 no row reopen on hits", ras_falls, f0);
        host_read(3, 0, d);
        check(ras_falls == f0 + 1, "R7 miss opens new row", ras_falls, f0 + 1);
        check(d == shadow[24], "R7 miss data", d, shadow[24]);

        // R9 long hit stream forces a close
        f0 = ras_falls;
        for (int k = 0; k < 24; k++) begin
            host_read(1, k % 8, d);
            check(d == shadow[8 + k % 8], "R9 stream data", d, shadow[8 + k % 8]);
        end
        check(ras_falls >= f0 + 2, "R9 forced page close", ras_falls, f0 + 2);
        // R9 idle open page closes
        host_read(0, 0, d);
        repeat (T_RASP_MAX + 20) @(negedge clk);
        check(ras_n == 1'b1, "R9 idle page closed", ras_n, 1'b1);
        check(max_lo <= T_RASP_MAX, "R9 longest row-low run", max_lo, T_RASP_MAX);

        // R11 refresh grant
        host_read(1, 1, d);
        @(negedge clk); #2;
        ref_grant = 1'b1;
        req_valid = 1'b1; req_we = 1'b0; req_addr = {rowf(1), colf(2)}; req_be = 2'b11;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #3;
            if (req_ready) bad++;
        end
        check(bad == 0, "R11 ready held low", bad, 0);
        check({ras_n, casl_n, cash_n} == 3'b111, "R11 bus parked", {ras_n, casl_n, cash_n}, 3'b111);
        f1 = ras_falls;
        ref_grant = 1'b0;
        #1;
        while (!req_ready) begin @(negedge clk); #3; end
        @(negedge clk); #2;
        req_valid = 1'b0;
        while (!rd_valid) @(negedge clk);
        check(rd_data == shadow[10], "R11 access after grant", rd_data, shadow[10]);
        check(ras_falls == f1 + 1, "R11 row reopened", ras_falls, f1 + 1);

        // timing summaries from the monitor
        repeat (10) @(negedge clk);
        check(rp_viol == 0, "R7 precharge length", rp_viol, 0);
        check(rasmin_viol == 0, "R8 row-low minimum", rasmin_viol, 0);
        check(rcd_viol == 0, "R8 row-to-column delay", rcd_viol, 0);
        check(cp_viol == 0, "R8 column precharge", cp_viol, 0);
        check(caslen_viol == 0, "R8 column-low length", caslen_viol, 0);
        check(we_viol == 0, "R5 early write order", we_viol, 0);
        check(drv_viol == 0, "R5 data drive window", drv_viol, 0);
        check(lat_viol == 0, "R10 capture latency", lat_viol, 0);
        finish_run();
    end

endmodule